// File: doc/BRIEF.md
# Constant On-Time Switching Cycle Sequencer

This block sequences the gate-drive requests of a constant on-time buck converter. A feedback comparator reports when the output has fallen to its trip level. The block answers with a high-side pulse of a programmed number of clock cycles. A low-side interval follows, and it lasts no less than a programmed minimum off-time. Every handover between the two switches passes through a programmed dead interval with both drives off. A valley current-limit comparator can hold the next high-side pulse back for as long as the inductor current stays above its limit.

A zero-crossing comparator reports when the inductor current reaches zero during the low-side interval. When light-load operation is permitted, the block watches for an unbroken run of switching cycles that each contain such a crossing. At the end of the run it enters power-save. In power-save the low-side switch is released at the crossing, and each on pulse is stretched by one fifth. The first cycle that closes without a crossing drops power-save and starts the run count again.

The comparator inputs are digital, already synchronised to the clock. The pulse lengths are counts taken from ports.

Top module: `cot_cycle_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `hs_drv`, `ls_drv` and `psave_on` are 0 after that edge. After reset is released, `ls_drv` first goes high on the `dead_len`-th clock edge (a count of 0 acts as 1), and `hs_drv` stays low until then.
- R2: `hs_drv` and `ls_drv` are never high in the same cycle. Every hand-over from high-side to low-side has exactly `dead_len` cycles (0 acts as 1) with both low. So does every hand-over from an unshortened low-side interval to high-side.
- R3: Each high-side pulse lasts the on-length chosen when the pulse was decided, which is the end of the low-side interval. This is `ton_len` cycles outside power-save (0 acts as 1). A change of `ton_len` after that point has no effect on the running pulse.
- R4: Outside power-save, a low-side interval lasts at least `toff_min` cycles (0 acts as 1). With `fb_trip` held high and `valley_limit` low, it lasts exactly `toff_min` cycles.
- R5: A low-side interval ends only at a clock edge where `fb_trip` is 1 and the minimum off-time has elapsed. When `fb_trip` rises after that time, `hs_drv` goes high `dead_len`+1 edges later.
- R6: While `valley_limit` is 1, no new pulse is decided. After it returns to 0, with the off-time elapsed and `fb_trip` high, `hs_drv` goes high `dead_len`+1 edges later.
- R7: A switching cycle ends when a new pulse is decided. It counts as a crossing cycle if `zero_cross` was 1 in any cycle of its low-side interval. With `psave_allow` = 1, `psave_on` goes high at the edge that ends the 8th consecutive crossing cycle (parameter `ZC_RUN`), and not earlier.
- R8: A switching cycle that ends without a crossing clears `psave_on` and the run count at that same edge.
- R9: In power-save, a `zero_cross` of 1 during the low-side interval turns `ls_drv` off at the next edge. It stays off until the next high-side pulse.
- R10: A pulse decided while in power-save lasts `ton_len + floor(ton_len/5)` cycles.
- R11: With `psave_allow` = 0, `psave_on` is 0 at the next edge and stays 0, while the run count keeps advancing. If `psave_allow` is raised after a full run, `psave_on` sets at the end of the next crossing cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fb_trip | input | 1 | Feedback at or below trip level: request a new on pulse |
| zero_cross | input | 1 | Inductor current has reached zero |
| valley_limit | input | 1 | Inductor current above the valley limit |
| psave_allow | input | 1 | Permit entry into power-save |
| ton_len | input | TW | High-side on length in clock cycles |
| toff_min | input | TW | Minimum low-side interval in clock cycles |
| dead_len | input | DW | Both-off interval in clock cycles |
| hs_drv | output | 1 | High-side drive request |
| ls_drv | output | 1 | Low-side drive request |
| psave_on | output | 1 | Power-save active |

## Verification
With the feedback trip held high, the sequencer free-runs, which pins the exact on, dead and minimum off lengths. Holding the trip low, or the valley limit high, separates "time elapsed" from "pulse allowed" and shows the measured launch delay. A steady zero-crossing input counts a run up to its threshold; removing it in one interval shows an exit on a single clean cycle. Toggling the permit input shows that counting and entry are separate. A seeded random mix of trip, crossing and limit inputs, run with random lengths that include zero, checks the pulse, gap and off-time rules on every cycle against lengths worked out by the bench.

// File: rtl/cot_pkg.sv
package cot_pkg;

  // Phases of one switching cycle, in the order they are visited.
  typedef enum logic [1:0] {
    PH_OFF    = 2'd0,  // low-side interval
    PH_DEAD_H = 2'd1,  // both off before the high side
    PH_HS     = 2'd2,  // high-side pulse
    PH_DEAD_L = 2'd3   // both off before the low side
  } cot_phase_e;

endpackage

// File: rtl/cot_phase_timer.sv
module cot_phase_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          expired
);

  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_eff;

  // A zero length is treated as one cycle.
  always_comb lim_eff = (limit == '0) ? ONE : limit;

  assign expired = (cnt_q >= (lim_eff - ONE));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  // R1: every phase change starts the count from zero
  p_restart_clears_r1: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0));

endmodule

// File: rtl/cot_len_ext.sv
module cot_len_ext #(
  parameter int LW  = 8,
  parameter int DIV = 5
) (
  input  logic [LW-1:0] len,
  output logic [LW:0]   stretched
);

  generate
    if (DIV > 0) begin : g_stretch
      localparam logic [LW-1:0] DIV_L = LW'(DIV);
      logic [LW-1:0] frac;
      assign frac      = len / DIV_L;
      assign stretched = {1'b0, len} + {1'b0, frac};
    end else begin : g_plain
      assign stretched = {1'b0, len};
    end
  endgenerate

endmodule

// File: rtl/cot_zc_track.sv
module cot_zc_track #(
  parameter int RUN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_end,
  input  logic zc_hit,
  input  logic allow,
  output logic psave_q,
  output logic psave_nx
);

  localparam int          RW    = $clog2(RUN + 1);
  localparam logic [RW-1:0] RUN_L = RW'(RUN);

  logic [RW-1:0] run_q, run_d;

  always_comb begin
    run_d    = run_q;
    psave_nx = psave_q && allow;
    if (cyc_end) begin
      if (zc_hit) begin
        run_d    = (run_q == RUN_L) ? run_q : run_q + RW'(1);
        psave_nx = allow && (run_d == RUN_L);
      end else begin
        run_d    = '0;
        psave_nx = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      psave_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      psave_q <= psave_nx;
    end
  end

  // R7: the run count saturates at its threshold
  p_run_bound_r7: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_L);

  // R7: completing the run with permission enters power-save
  p_enter_r7: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && zc_hit && allow && (run_q == RUN_L - RW'(1))) |=> psave_q);

  // R8: a cycle without a crossing drops the mode and the count
  p_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && !zc_hit) |=> (!psave_q && (run_q == '0)));

  // R11: the mode is never held without permission
  p_allow_r11: assert property (@(posedge clk) disable iff (rst)
    psave_q |-> $past(allow));

endmodule

// File: rtl/cot_cycle_ctrl.sv
module cot_cycle_ctrl
  import cot_pkg::*;
#(
  parameter int TW      = 8,
  parameter int DW      = 4,
  parameter int ZC_RUN  = 8,
  parameter int EXT_DIV = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fb_trip,
  input  logic          zero_cross,
  input  logic          valley_limit,
  input  logic          psave_allow,
  input  logic [TW-1:0] ton_len,
  input  logic [TW-1:0] toff_min,
  input  logic [DW-1:0] dead_len,
  output logic          hs_drv,
  output logic          ls_drv,
  output logic          psave_on
);

  localparam int CW = TW + 1;

  cot_phase_e    phase_q, phase_d;
  logic [CW-1:0] tmr_lim;
  logic          tmr_done;
  logic          phase_chg;
  logic [CW-1:0] on_lat_q;
  logic [CW-1:0] ext_len;
  logic          zc_flag_q;
  logic          zc_hit;
  logic          cyc_end;
  logic          psave_q, psave_d;
  logic          blk_q, blk_d, blk_set;
  logic          hs_q, ls_q;

  // Length of the phase in progress
  always_comb begin
    unique case (phase_q)
      PH_OFF:  tmr_lim = CW'(toff_min);
      PH_HS:   tmr_lim = on_lat_q;
      default: tmr_lim = CW'(dead_len);
    endcase
  end

  cot_phase_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (phase_chg),
    .limit   (tmr_lim),
    .expired (tmr_done)
  );

  // A new pulse is decided when off-time is over, feedback trips and
  // the valley limit is clear.
  assign cyc_end = (phase_q == PH_OFF) && tmr_done && fb_trip && !valley_limit;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_OFF:    if (cyc_end)  phase_d = PH_DEAD_H;
      PH_DEAD_H: if (tmr_done) phase_d = PH_HS;
      PH_HS:     if (tmr_done) phase_d = PH_DEAD_L;
      PH_DEAD_L: if (tmr_done) phase_d = PH_OFF;
      default:                 phase_d = PH_DEAD_L;
    endcase
  end

  assign phase_chg = (phase_d != phase_q);

  // Zero crossings seen during the current low-side interval
  assign zc_hit = zc_flag_q || ((phase_q == PH_OFF) && zero_cross);

  always_ff @(posedge clk) begin
    if (rst || cyc_end) begin
      zc_flag_q <= 1'b0;
    end else if ((phase_q == PH_OFF) && zero_cross) begin
      zc_flag_q <= 1'b1;
    end
  end

  cot_zc_track #(.RUN(ZC_RUN)) u_zc (
    .clk      (clk),
    .rst      (rst),
    .cyc_end  (cyc_end),
    .zc_hit   (zc_hit),
    .allow    (psave_allow),
    .psave_q  (psave_q),
    .psave_nx (psave_d)
  );

  cot_len_ext #(.LW(TW), .DIV(EXT_DIV)) u_ext (
    .len       (ton_len),
    .stretched (ext_len)
  );

  // On length fixed when the pulse is decided, using the mode it will run in
  always_ff @(posedge clk) begin
    if (rst) begin
      on_lat_q <= '0;
    end else if (cyc_end) begin
      on_lat_q <= psave_d ? ext_len : CW'(ton_len);
    end
  end

  // Low-side release at a zero crossing while in power-save
  assign blk_set = (phase_q == PH_OFF) && psave_q && zero_cross;
  assign blk_d   = (phase_d == PH_OFF) && (blk_q || blk_set);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_DEAD_L;
      blk_q   <= 1'b0;
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      blk_q   <= blk_d;
      hs_q    <= (phase_d == PH_HS);
      ls_q    <= (phase_d == PH_OFF) && !blk_d;
    end
  end

  assign hs_drv   = hs_q;
  assign ls_drv   = ls_q;
  assign psave_on = psave_q;

  // R2: the two drives are never on together
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
    !(hs_drv && ls_drv));

  // R2: high side rises only after a cycle with the low side off
  p_hs_gap_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_drv) |-> !$past(ls_drv));

  // R2: low side rises only after a cycle with the high side off
  p_ls_gap_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_drv) |-> !$past(hs_drv));

  // R3: the on length does not move during a pulse
  p_onlen_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HS) |-> $stable(on_lat_q));

  // R6: an asserted valley limit keeps the low-side phase
  p_valley_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_OFF) && valley_limit) |=> (phase_q == PH_OFF));

  // R9: a crossing in power-save releases the low side next cycle
  p_ls_cut_r9: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_OFF) && psave_on && zero_cross) |=> !ls_drv);

endmodule

// File: tb/cot_cycle_ctrl_tb.sv
module cot_cycle_ctrl_tb;

  localparam int TW = 8;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fb_trip = 1'b0;
  logic          zero_cross = 1'b0;
  logic          valley_limit = 1'b0;
  logic          psave_allow = 1'b0;
  logic [TW-1:0] ton_len = 8'd10;
  logic [TW-1:0] toff_min = 8'd4;
  logic [DW-1:0] dead_len = 4'd2;
  logic          hs_drv, ls_drv, psave_on;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cot_cycle_ctrl #(.TW(TW), .DW(DW)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .fb_trip      (fb_trip),
    .zero_cross   (zero_cross),
    .valley_limit (valley_limit),
    .psave_allow  (psave_allow),
    .ton_len      (ton_len),
    .toff_min     (toff_min),
    .dead_len     (dead_len),
    .hs_drv       (hs_drv),
    .ls_drv       (ls_drv),
    .psave_on     (psave_on)
  );

  function automatic int f_eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int f_on(int t, bit ps);
    return f_eff(ps ? (t + t / 5) : t);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // ---------------- cycle monitor ----------------
  bit hs_p, ls_p, ps_at_rise, gv_h, gv_l;
  int gap, hs_w, exp_w, ls_w, overlap;

  always @(negedge clk) begin
    if (rst) begin
      hs_p = 0; ls_p = 0; gv_h = 0; gv_l = 0; gap = 0; hs_w = 0; ls_w = 0;
      ps_at_rise = 0;
    end else begin
      if (hs_drv && ls_drv) overlap++;
      // both-off gap length
      if ((!hs_drv && hs_p) || (!ls_drv && ls_p)) gap = 1;
      else if (!hs_drv && !ls_drv) gap++;
      // high side
      if (hs_drv && !hs_p) begin
        if (gv_h) check(gap == f_eff(int'(dead_len)), "R2 gap before high side", gap, f_eff(int'(dead_len)));
        gv_h  = 0;
        exp_w = f_on(int'(ton_len), psave_on);
        hs_w  = 1;
      end else if (hs_drv) hs_w++;
      if (!hs_drv && hs_p) begin
        check(hs_w == exp_w, "R3/R10 on pulse width", hs_w, exp_w);
        gv_l = 1;
      end
      // low side
      if (ls_drv && !ls_p) begin
        if (gv_l) check(gap == f_eff(int'(dead_len)), "R2 gap before low side", gap, f_eff(int'(dead_len)));
        ls_w = 1;
        ps_at_rise = psave_on;
      end else if (ls_drv) ls_w++;
      if (!ls_drv && ls_p) begin
        if (!ps_at_rise) check(ls_w >= f_eff(int'(toff_min)), "R4 minimum off time", ls_w, f_eff(int'(toff_min)));
        gv_h = !ps_at_rise;
      end
      hs_p = hs_drv;
      ls_p = ls_drv;
    end
  end

  // ---------------- helpers ----------------
  task automatic do_reset(int ton, int toff, int dd, bit allow);
    @(negedge clk);
    #1;
    rst = 1; fb_trip = 0; zero_cross = 0; valley_limit = 0;
    psave_allow = allow; ton_len = TW'(ton); toff_min = TW'(toff); dead_len = DW'(dd);
    repeat (3) @(negedge clk);
    check(!hs_drv && !ls_drv && !psave_on, "R1 reset state", {hs_drv, ls_drv, psave_on}, 0);
    #1 rst = 0;
  endtask

  task automatic wait_ls_fall();
    bit p;
    p = ls_drv;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (p && !ls_drv) return;
      p = ls_drv;
    end
  endtask

  task automatic wait_ls_rise();
    bit p;
    p = ls_drv;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!p && ls_drv) return;
      p = ls_drv;
    end
  endtask

  task automatic wait_hs_rise();
    bit p;
    p = hs_drv;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!p && hs_drv) return;
      p = hs_drv;
    end
  endtask

  // called at the negedge of a rise; returns the high count of the signal
  task automatic measure(bit use_hs, output int w);
    w = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (use_hs ? !hs_drv : !ls_drv) return;
      w++;
    end
  endtask

  task automatic edges_to_hs(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      n++;
      if (hs_drv) return;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(8 * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int  n, w;
    bit  seen, ps_before, p;
    void'($urandom(32'h5eed_0c07));

    // R1: first low-side turn-on after reset
    do_reset(10, 4, 2, 0);
    fb_trip = 1;
    n = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      n++;
      if (ls_drv || hs_drv) break;
    end
    check(n == 2 && !hs_drv, "R1 low side after dead time", n, 2);

    // R4: free-running off interval is exact
    wait_ls_rise();
    measure(0, w);
    check(w == 4, "R4 exact off interval", w, 4);

    // R5: feedback gating
    wait_ls_rise();
    #1 fb_trip = 0;
    seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (hs_drv || !ls_drv) seen = 1;
    end
    check(!seen, "R5 no pulse without trip", seen, 0);
    #1 fb_trip = 1;
    edges_to_hs(n);
    check(n == 3, "R5 launch delay after trip", n, 3);

    // R6: valley limit hold-off
    wait_ls_rise();
    #1 valley_limit = 1;
    seen = 0;
    repeat (25) begin
      @(negedge clk);
      if (hs_drv) seen = 1;
    end
    check(!seen, "R6 pulse held by valley limit", seen, 0);
    #1 valley_limit = 0;
    edges_to_hs(n);
    check(n == 3, "R6 launch delay after limit clears", n, 3);

    // R3: on length latched at decision
    wait_hs_rise();
    #1 ton_len = 8'd3;
    measure(1, w);
    check(w == 10, "R3 running pulse keeps latched length", w, 10);
    wait_hs_rise();
    #1 ton_len = 8'd10;
    measure(1, w);
    check(w == 3, "R3 next pulse takes new length", w, 3);

    // R7: entry after eight crossing cycles
    do_reset(10, 4, 2, 1);
    fb_trip = 1; zero_cross = 1;
    for (int i = 1; i <= 8; i++) begin
      wait_ls_fall();
      if (i == 7) check(psave_on == 0, "R7 no entry after seven cycles", psave_on, 0);
      if (i == 8) check(psave_on == 1, "R7 entry after eighth cycle", psave_on, 1);
    end

    // R9: low side released at the crossing
    wait_ls_rise();
    @(negedge clk);
    check(!ls_drv && !hs_drv, "R9 low side released", ls_drv, 0);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      if (hs_drv) break;
      if (ls_drv) seen = 1;
      @(negedge clk);
    end
    check(!seen && hs_drv, "R9 low side stays off until pulse", seen, 0);

    // R10: stretched pulse
    wait_hs_rise();
    measure(1, w);
    check(w == 12, "R10 stretched on pulse", w, 12);

    // R8: one clean cycle exits
    wait_hs_rise();
    #1 zero_cross = 0;
    p = ls_drv;
    ps_before = psave_on;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (p && !ls_drv) break;
      ps_before = psave_on;
      p = ls_drv;
    end
    check(ps_before && !psave_on, "R8 exit at clean cycle end", psave_on, 0);

    // R11: permission gates entry, count keeps running
    do_reset(10, 4, 2, 0);
    fb_trip = 1; zero_cross = 1;
    seen = 0;
    repeat (10) begin
      wait_ls_fall();
      if (psave_on) seen = 1;
    end
    check(!seen, "R11 no entry without permission", seen, 0);
    #1 psave_allow = 1;
    wait_ls_fall();
    check(psave_on == 1, "R11 entry on next crossing cycle", psave_on, 1);
    wait_hs_rise();
    #1 psave_allow = 0;
    @(negedge clk);
    check(psave_on == 0, "R11 permission removal clears mode", psave_on, 0);
    wait_hs_rise();

    // constrained random phases
    for (int ph = 0; ph < 10; ph++) begin
      do_reset($urandom_range(0, 20), $urandom_range(0, 10), $urandom_range(0, 3),
               1'($urandom_range(0, 1)));
      repeat (400) begin
        @(negedge clk);
        #1;
        fb_trip      = ($urandom_range(0, 9) < 7);
        zero_cross   = 1'($urandom_range(0, 1));
        valley_limit = ($urandom_range(0, 9) == 0);
      end
    end

    check(overlap == 0, "R2 drives never overlap", overlap, 0);
    summary();
    $finish;
  end

endmodule